// File: doc/BRIEF.md
# Contactless Sector Permission Evaluator

This block decides, for every one of 64 memory sectors, whether the contactless side may read it and whether it may write it. Each sector keeps a small security status byte. The byte holds a lock flag, a two-bit protection code and a two-bit link that ties the sector to one of three stored 32-bit keys. The block also remembers which key, if any, has been correctly shown during the current power cycle. A sector's rights come from its protection code together with whether its linked key is the one currently shown.

Commands enter on a valid/ready stream. There are three of them: lock a sector, present a key, and replace a key. Each accepted command produces one response beat on a second valid/ready stream that carries a pass/fail flag. A command is accepted when `cmd_valid` and `cmd_ready` are both high on a rising edge. `cmd_ready` is high whenever the response slot is empty, or when its beat is being taken in that same cycle. A response beat stays valid and unchanged until `rsp_ready` is high.

The contact side can overwrite any status byte directly through a plain write port. A combinational query port reports the status byte and the two permission flags for any sector index.

Top module: `sector_guard`

## Requirements
- R1: `q_status` shows the queried sector's status byte. Bit 0 is the lock flag, bits 2:1 are the protection code, bits 4:3 are the key link, and bits 7:5 always read 0.
- R2: After reset every status byte is 00h, all three keys are 00000000h and no key is shown.
- R3: A sector whose lock flag is 0 is both readable and writable, whatever key is shown.
- R4: For a locked sector whose linked key is the shown key, codes 00, 01 and 10 give read and write, and code 11 gives read only.
- R5: For a locked sector whose linked key is not shown, code 00 gives read only, code 01 gives read and write, and codes 10 and 11 give no access.
- R6: A lock command (`cmd_op`=01) sent to an unlocked sector sets its byte to {000, `cmd_key`, `cmd_prot`, 1} and responds ok=1. Sent to a sector that is already locked, it leaves the byte unchanged and responds ok=0.
- R7: A present command (`cmd_op`=10) with `cmd_key` in 1..3 and `cmd_value` equal to that key makes that key the shown key and responds ok=1. Any other present, including a wrong value or key number 0, leaves no key shown and responds ok=0.
- R8: Link 00 never counts as shown. A locked sector with link 00 therefore always follows the R5 rights.
- R9: A replace-key command (`cmd_op`=11) stores `cmd_value` into key `cmd_key` and responds ok=1 only when that key is the shown key. Otherwise it changes nothing and responds ok=0.
- R10: A contact-side write (`host_wr_en`) sets that sector's byte to {000, `host_wr_fields`}, whether or not the sector is locked. It takes effect on the next edge.
- R11: The response for an accepted command is valid on the cycle after acceptance. `cmd_ready` equals !`rsp_valid` || `rsp_ready`. A beat that is not taken holds `rsp_ok`. Operation code 00 responds ok=0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Command beat may be taken |
| cmd_op | input | 2 | 00 none, 01 lock, 10 present, 11 replace key |
| cmd_sector | input | 6 | Sector index for lock |
| cmd_key | input | 2 | Key number (present/replace) or link (lock) |
| cmd_prot | input | 2 | Protection code for lock |
| cmd_value | input | 32 | Key value for present/replace |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat taken |
| rsp_ok | output | 1 | 1 when the command succeeded |
| host_wr_en | input | 1 | Contact-side status write strobe |
| host_wr_sector | input | 6 | Sector of the contact-side write |
| host_wr_fields | input | 5 | New status bits 4:0 |
| q_sector | input | 6 | Sector to evaluate |
| q_status | output | 8 | Status byte of `q_sector` |
| q_rd_ok | output | 1 | Contactless read allowed |
| q_wr_ok | output | 1 | Contactless write allowed |

## Verification
The shown-key register is never visible at the ports. A corrupted value in it therefore shows up only through the permission flags of a locked sector, or through the ok flag of a later replace-key command. The bench probes those flags on the cycle after each present command. A wrong status byte appears at once on `q_status` and the flags for that sector. A lost or duplicated response shows up as a scoreboard mismatch on the next beat.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_LOCK    = 2'b01,
    OP_PRESENT = 2'b10,
    OP_SETKEY  = 2'b11
  } sg_op_e;

  typedef struct packed {
    logic [2:0] zero;
    logic [1:0] link;
    logic [1:0] code;
    logic       lock;
  } sg_status_t;
endpackage

// File: rtl/sg_status_bank.sv
module sg_status_bank
  import sg_pkg::*;
#(
  parameter int NSEC  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_req,
  input  logic [IDX_W-1:0] lock_sector,
  input  logic [1:0]       lock_link,
  input  logic [1:0]       lock_code,
  output logic             lock_ok,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_sector,
  input  logic [4:0]       host_fields,
  input  logic [IDX_W-1:0] q_sector,
  output sg_status_t       q_status
);
  sg_status_t st [NSEC];

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic host_hit;
    logic lock_hit;
    assign host_hit = host_we && (host_sector == IDX_W'(g));
    assign lock_hit = lock_req && (lock_sector == IDX_W'(g)) && !st[g].lock;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[g] <= '0;
      end else if (host_hit) begin
        st[g] <= sg_status_t'({3'b000, host_fields});
      end else if (lock_hit) begin
        st[g].zero <= 3'b000;
        st[g].link <= lock_link;
        st[g].code <= lock_code;
        st[g].lock <= 1'b1;
      end
    end
  end

  assign lock_ok  = !st[lock_sector].lock;
  assign q_status = st[q_sector];
endmodule

// File: rtl/sg_key_store.sv
module sg_key_store #(
  parameter int NKEY  = 3,
  parameter int KEY_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             present_req,
  input  logic             setkey_req,
  input  logic [SEL_W-1:0] sel,
  input  logic [KEY_W-1:0] value,
  output logic             present_ok,
  output logic             setkey_ok,
  output logic [SEL_W-1:0] active_sel
);
  logic [KEY_W-1:0] keys [NKEY];
  logic [KEY_W-1:0] cur_key;
  logic             sel_valid;

  always_comb begin
    cur_key   = '0;
    sel_valid = 1'b0;
    for (int i = 0; i < NKEY; i++) begin
      if (sel == SEL_W'(i + 1)) begin
        cur_key   = keys[i];
        sel_valid = 1'b1;
      end
    end
  end

  assign present_ok = sel_valid && (cur_key == value);
  assign setkey_ok  = sel_valid && (active_sel == sel);

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        keys[k] <= '0;
      end else if (setkey_req && setkey_ok && sel == SEL_W'(k + 1)) begin
        keys[k] <= value;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_sel <= '0;
    end else if (present_req) begin
      active_sel <= present_ok ? sel : '0;
    end
  end
endmodule

// File: rtl/sg_perm_decode.sv
module sg_perm_decode
  import sg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  sg_status_t       status,
  input  logic [SEL_W-1:0] active_sel,
  output logic             rd_ok,
  output logic             wr_ok
);
  logic shown;
  assign shown = (status.link != 2'b00) && (SEL_W'(status.link) == active_sel);

  always_comb begin
    rd_ok = 1'b1;
    wr_ok = 1'b1;
    if (status.lock) begin
      if (shown) begin
        wr_ok = (status.code != 2'b11);
      end else begin
        unique case (status.code)
          2'b00:   begin rd_ok = 1'b1; wr_ok = 1'b0; end
          2'b01:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
          default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
      end
    end
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NSEC  = 64,
  parameter int NKEY  = 3,
  parameter int KEY_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [$clog2(NSEC)-1:0]  cmd_sector,
  input  logic [1:0]               cmd_key,
  input  logic [1:0]               cmd_prot,
  input  logic [KEY_W-1:0]         cmd_value,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic                     rsp_ok,
  input  logic                     host_wr_en,
  input  logic [$clog2(NSEC)-1:0]  host_wr_sector,
  input  logic [4:0]               host_wr_fields,
  input  logic [$clog2(NSEC)-1:0]  q_sector,
  output logic [7:0]               q_status,
  output logic                     q_rd_ok,
  output logic                     q_wr_ok
);
  localparam int SEC_IDX_W = $clog2(NSEC);
  localparam int SEL_W     = 2;

  sg_op_e     op;
  logic       fire;
  logic       lock_ok, present_ok, setkey_ok, ok_n;
  logic [SEL_W-1:0] active_sel;
  sg_status_t stat_q;

  assign op        = sg_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  sg_status_bank #(.NSEC(NSEC), .IDX_W(SEC_IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_req   (fire && op == OP_LOCK),
    .lock_sector(cmd_sector),
    .lock_link  (cmd_key),
    .lock_code  (cmd_prot),
    .lock_ok    (lock_ok),
    .host_we    (host_wr_en),
    .host_sector(host_wr_sector),
    .host_fields(host_wr_fields),
    .q_sector   (q_sector),
    .q_status   (stat_q)
  );

  sg_key_store #(.NKEY(NKEY), .KEY_W(KEY_W), .SEL_W(SEL_W)) u_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .present_req(fire && op == OP_PRESENT),
    .setkey_req (fire && op == OP_SETKEY),
    .sel        (cmd_key),
    .value      (cmd_value),
    .present_ok (present_ok),
    .setkey_ok  (setkey_ok),
    .active_sel (active_sel)
  );

  sg_perm_decode #(.SEL_W(SEL_W)) u_perm (
    .status    (stat_q),
    .active_sel(active_sel),
    .rd_ok     (q_rd_ok),
    .wr_ok     (q_wr_ok)
  );

  assign q_status = stat_q;

  always_comb begin
    unique case (op)
      OP_LOCK:    ok_n = lock_ok;
      OP_PRESENT: ok_n = present_ok;
      OP_SETKEY:  ok_n = setkey_ok;
      default:    ok_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_ok    <= ok_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_ok,
  input logic             host_wr_en,
  input logic [IDX_W-1:0] q_sector,
  input logic [7:0]       q_status,
  input logic             q_rd_ok,
  input logic             q_wr_ok
);
  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q_status[7:5] == 3'b000); // R1
  AST_UNLOCKED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !q_status[0] |-> (q_rd_ok && q_wr_ok)); // R3
  AST_NO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr_ok |-> q_rd_ok); // R4
  AST_CODE3_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status[0] && q_status[2:1] == 2'b11) |-> !q_wr_ok); // R5
  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (q_status[0] && !host_wr_en) |=> (($past(q_sector) != q_sector) || $stable(q_status))); // R6
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid); // R11
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok))); // R11
endmodule

bind sector_guard sg_guard_chk #(.IDX_W(SEC_IDX_W)) u_chk (.*);

// File: tb/test_sector_guard.sv
`timescale 1ns/1ps
module test_sector_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready;
  logic [1:0]  cmd_op, cmd_key, cmd_prot;
  logic [5:0]  cmd_sector;
  logic [31:0] cmd_value;
  logic        rsp_valid, rsp_ready, rsp_ok;
  logic        host_wr_en;
  logic [5:0]  host_wr_sector;
  logic [4:0]  host_wr_fields;
  logic [5:0]  q_sector;
  logic [7:0]  q_status;
  logic        q_rd_ok, q_wr_ok;

  int n_checks = 0;
  int n_fail   = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sector_guard i_sector_guard (.*);

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 unexpected response: actual ok=%0d expected none", rsp_ok);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_ok !== e) begin
          n_fail++;
          $display("FAIL %s response: actual ok=%0d expected %0d", t, rsp_ok, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [5:0] sec, input logic [1:0] key,
                      input logic [1:0] prot, input logic [31:0] val, input logic e, input string tag);
    @(negedge clk);
    cmd_op = op; cmd_sector = sec; cmd_key = key; cmd_prot = prot; cmd_value = val;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic host_write(input logic [5:0] sec, input logic [4:0] f);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_sector = sec; host_wr_fields = f;
    @(posedge clk);
    #1 host_wr_en = 1'b0;
  endtask

  task automatic probe(input logic [5:0] sec, input logic [7:0] st, input logic rd,
                       input logic wr, input string tag);
    @(negedge clk);
    q_sector = sec;
    #1;
    chk({tag, " status"}, {24'h0, q_status}, {24'h0, st});
    chk({tag, " rd/wr"}, {30'h0, q_rd_ok, q_wr_ok}, {30'h0, rd, wr});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_sector = '0; cmd_key = '0;
    cmd_prot = '0; cmd_value = '0; rsp_ready = 1'b1; host_wr_en = 1'b0;
    host_wr_sector = '0; host_wr_fields = '0; q_sector = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    probe(6'd5, 8'h00, 1'b1, 1'b1, "R2 reset sector5");
    probe(6'd63, 8'h00, 1'b1, 1'b1, "R3 reset sector63");

    // R6 lock sectors 0..3 linked to key 1 with codes 00..11
    send(2'b01, 6'd0, 2'd1, 2'b00, 32'h0, 1'b1, "R6 lock s0");
    send(2'b01, 6'd1, 2'd1, 2'b01, 32'h0, 1'b1, "R6 lock s1");
    send(2'b01, 6'd2, 2'd1, 2'b10, 32'h0, 1'b1, "R6 lock s2");
    send(2'b01, 6'd3, 2'd1, 2'b11, 32'h0, 1'b1, "R6 lock s3");
    probe(6'd0, 8'h09, 1'b1, 1'b0, "R5 s0 code00 not shown");
    probe(6'd1, 8'h0B, 1'b1, 1'b1, "R5 s1 code01 not shown");
    probe(6'd2, 8'h0D, 1'b0, 1'b0, "R5 s2 code10 not shown");
    probe(6'd3, 8'h0F, 1'b0, 1'b0, "R5 s3 code11 not shown");
    send(2'b01, 6'd0, 2'd3, 2'b11, 32'h0, 1'b0, "R6 relock s0");
    probe(6'd0, 8'h09, 1'b1, 1'b0, "R6 relock s0 unchanged");

    // R7 / R2 default key value 0
    send(2'b10, 6'd0, 2'd1, 2'b00, 32'h0, 1'b1, "R7 present key1 default");
    probe(6'd0, 8'h09, 1'b1, 1'b1, "R4 s0 code00 shown");
    probe(6'd2, 8'h0D, 1'b1, 1'b1, "R4 s2 code10 shown");
    probe(6'd3, 8'h0F, 1'b1, 1'b0, "R4 s3 code11 shown");

    // R9 replace key
    send(2'b11, 6'd0, 2'd1, 2'b00, 32'hA5A5_1234, 1'b1, "R9 replace shown key1");
    send(2'b11, 6'd0, 2'd2, 2'b00, 32'h1111_2222, 1'b0, "R9 replace unshown key2");
    send(2'b10, 6'd0, 2'd1, 2'b00, 32'h0000_0001, 1'b0, "R7 wrong key1");
    probe(6'd2, 8'h0D, 1'b0, 1'b0, "R7 revoked s2");
    send(2'b11, 6'd0, 2'd1, 2'b00, 32'h0, 1'b0, "R9 replace after revoke");
    send(2'b10, 6'd0, 2'd1, 2'b00, 32'hA5A5_1234, 1'b1, "R9 new key1 accepted");
    probe(6'd2, 8'h0D, 1'b1, 1'b1, "R7 s2 regained");
    send(2'b10, 6'd0, 2'd2, 2'b00, 32'h0, 1'b1, "R9 key2 kept default");
    probe(6'd2, 8'h0D, 1'b0, 1'b0, "R7 key2 replaces key1");

    // R8 link 00
    send(2'b01, 6'd10, 2'd0, 2'b00, 32'h0, 1'b1, "R8 lock s10 link0");
    send(2'b10, 6'd0, 2'd0, 2'b00, 32'h0, 1'b0, "R8 present key0");
    probe(6'd10, 8'h01, 1'b1, 1'b0, "R8 s10 after key0");
    send(2'b10, 6'd0, 2'd2, 2'b00, 32'h0, 1'b1, "R8 present key2");
    probe(6'd10, 8'h01, 1'b1, 1'b0, "R8 s10 after key2");

    // R10 contact-side write
    host_write(6'd0, 5'h1F);
    probe(6'd0, 8'h1F, 1'b0, 1'b0, "R10 s0 overwritten");
    host_write(6'd0, 5'h00);
    probe(6'd0, 8'h00, 1'b1, 1'b1, "R10 s0 unlocked");
    send(2'b01, 6'd0, 2'd2, 2'b11, 32'h0, 1'b1, "R10 relock after host");
    probe(6'd0, 8'h17, 1'b1, 1'b0, "R4 s0 code11 key2 shown");

    // R11 no-op and back-pressure
    send(2'b00, 6'd4, 2'd1, 2'b01, 32'h0, 1'b0, "R11 op00");
    probe(6'd4, 8'h00, 1'b1, 1'b1, "R11 op00 no effect");
    @(negedge clk) rsp_ready = 1'b0;
    send(2'b10, 6'd0, 2'd3, 2'b00, 32'h0, 1'b1, "R11 held response");
    @(negedge clk);
    chk("R11 valid held", {31'h0, rsp_valid}, 32'h1);
    chk("R11 ready low", {31'h0, cmd_ready}, 32'h0);
    @(negedge clk);
    chk("R11 valid held 2", {31'h0, rsp_valid}, 32'h1);
    @(posedge clk);
    #1 rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 queue drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule